// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a single device. It takes a test clock, a mode-select line and a serial data input. A sixteen-state controller, clocked by the test clock and steered by the mode-select line, walks the standard capture, shift and update sequence. A 10-bit instruction register picks which data register sits between the serial input and the serial output. The block holds three data registers of its own: a one-bit bypass stage, a 32-bit identification word and a 32-bit user word.

The boundary register is outside this block. The port drives it through a select line and three per-phase clock enables (capture, shift, update), and takes its serial output back in on `bsr_tdo`. Two mode outputs tell the pad ring whether the pins follow the boundary cells or float. Scans work while the rest of the device keeps running. Only the pad-control modes change what the pins do.

The reset input `rst` is synchronous and active high, and acts as the optional test reset. The serial output changes on the falling edge of the test clock. All other state moves on the rising edge.

Top module: `tap_port`

## Requirements
- R1: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the identification instruction becomes active.
- R2: State transitions follow the standard 16-state graph, and `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR.
- R3: On Capture-IR the instruction shift register loads 10'b0101010101. Shifting is LSB first, so the first bits out are 1, 0, 1, 0.
- R4: The active instruction changes only on the rising edge that leaves Update-IR. Shifting a new opcode leaves the decoded outputs unchanged until then.
- R5: Opcode 10'b0000000110 (also the reset default) selects the 32-bit identification word {version[3:0], part[15:0], maker[10:0], 1'b1}, shifted out LSB first.
- R6: Opcode 10'b0000000111 selects the 32-bit user word, shifted out LSB first.
- R7: Opcode 10'b1111111111 selects the 1-bit bypass stage. It captures 0, so the output stream is a 0 followed by the input delayed by one bit.
- R8: The clamp (10'b0000001010), float (10'b0000001011), I/O-configuration (10'b0000001101) and every unlisted opcode select the bypass stage.
- R9: Opcodes 10'b0000000000 (external test) and 10'b0000000101 (sample) raise `bsr_sel`, route `bsr_tdo` to `tdo` in Shift-DR, and pulse `bsr_capture`, `bsr_shift` and `bsr_update` in Capture-DR, Shift-DR and Update-DR.
- R10: `pins_from_bsr` is high for external test and clamp. `pins_hiz` is high for the float opcode only. The two are never high together.
- R11: `tdo` and `tdo_en` change only on the falling edge of `tck`. Shift registers sample `tdi` on the rising edge.
- R12: `rst` high at a rising edge forces Test-Logic-Reset and the identification instruction, and clears `tdo_en` at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Output enable for tdo, high in shift states |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| bsr_sel | output | 1 | Boundary register is the selected data register |
| bsr_capture | output | 1 | Boundary register capture enable |
| bsr_shift | output | 1 | Boundary register shift enable |
| bsr_update | output | 1 | Boundary register update enable |
| pins_from_bsr | output | 1 | Pins are driven from boundary cells |
| pins_hiz | output | 1 | Pins are floated |

## Verification
A wrong controller state shows up at `tdo_en` at the next falling edge, and as a misplaced boundary-register strobe in the same cycle. A wrong instruction register shows up at once on the mode outputs and `bsr_sel`. It also shows up within one scan as a wrong stream on `tdo`, for example a bypass delay where a 32-bit word was expected. Corrupted capture values show up on the first bit shifted out after the capture state.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    TS_RESET  = 4'h0,
    TS_IDLE   = 4'h1,
    TS_DR_SEL = 4'h2,
    TS_DR_CAP = 4'h3,
    TS_DR_SHF = 4'h4,
    TS_DR_EX1 = 4'h5,
    TS_DR_PAU = 4'h6,
    TS_DR_EX2 = 4'h7,
    TS_DR_UPD = 4'h8,
    TS_IR_SEL = 4'h9,
    TS_IR_CAP = 4'hA,
    TS_IR_SHF = 4'hB,
    TS_IR_EX1 = 4'hC,
    TS_IR_PAU = 4'hD,
    TS_IR_EX2 = 4'hE,
    TS_IR_UPD = 4'hF
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 10'b0000000000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'b0000000101;
  localparam logic [IR_W-1:0] OP_IDENT  = 10'b0000000110;
  localparam logic [IR_W-1:0] OP_USER   = 10'b0000000111;
  localparam logic [IR_W-1:0] OP_CLAMP  = 10'b0000001010;
  localparam logic [IR_W-1:0] OP_FLOAT  = 10'b0000001011;
  localparam logic [IR_W-1:0] OP_IOCFG  = 10'b0000001101;
  localparam logic [IR_W-1:0] OP_BYPASS = 10'b1111111111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'b0101010101;

  typedef enum logic [1:0] {
    DR_BYPASS   = 2'd0,
    DR_IDENT    = 2'd1,
    DR_USER     = 2'd2,
    DR_BOUNDARY = 2'd3
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    pins_from_bsr;
    logic    pins_hiz;
  } ins_dec_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_DR_SEL : TS_IDLE;
      TS_DR_SEL: nxt = tms ? TS_IR_SEL : TS_DR_CAP;
      TS_DR_CAP: nxt = tms ? TS_DR_EX1 : TS_DR_SHF;
      TS_DR_SHF: nxt = tms ? TS_DR_EX1 : TS_DR_SHF;
      TS_DR_EX1: nxt = tms ? TS_DR_UPD : TS_DR_PAU;
      TS_DR_PAU: nxt = tms ? TS_DR_EX2 : TS_DR_PAU;
      TS_DR_EX2: nxt = tms ? TS_DR_UPD : TS_DR_SHF;
      TS_DR_UPD: nxt = tms ? TS_DR_SEL : TS_IDLE;
      TS_IR_SEL: nxt = tms ? TS_RESET  : TS_IR_CAP;
      TS_IR_CAP: nxt = tms ? TS_IR_EX1 : TS_IR_SHF;
      TS_IR_SHF: nxt = tms ? TS_IR_EX1 : TS_IR_SHF;
      TS_IR_EX1: nxt = tms ? TS_IR_UPD : TS_IR_PAU;
      TS_IR_PAU: nxt = tms ? TS_IR_EX2 : TS_IR_PAU;
      TS_IR_EX2: nxt = tms ? TS_IR_UPD : TS_IR_SHF;
      TS_IR_UPD: nxt = tms ? TS_DR_SEL : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= TS_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_act
);

  always_ff @(posedge tck) begin
    if (rst)                     ir_shift <= '0;
    else if (state == TS_IR_CAP) ir_shift <= IR_CAPTURE;
    else if (state == TS_IR_SHF) ir_shift <= {tdi, ir_shift[IR_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (rst || state == TS_RESET) ir_act <= OP_IDENT;
    else if (state == TS_IR_UPD)  ir_act <= ir_shift;
  end

endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
(
  input  logic [IR_W-1:0] ir_act,
  output ins_dec_t        dec
);

  always_comb begin
    dec = '{sel: DR_BYPASS, pins_from_bsr: 1'b0, pins_hiz: 1'b0};
    case (ir_act)
      OP_EXTEST: dec = '{sel: DR_BOUNDARY, pins_from_bsr: 1'b1, pins_hiz: 1'b0};
      OP_SAMPLE: dec = '{sel: DR_BOUNDARY, pins_from_bsr: 1'b0, pins_hiz: 1'b0};
      OP_IDENT:  dec = '{sel: DR_IDENT,    pins_from_bsr: 1'b0, pins_hiz: 1'b0};
      OP_USER:   dec = '{sel: DR_USER,     pins_from_bsr: 1'b0, pins_hiz: 1'b0};
      OP_CLAMP:  dec = '{sel: DR_BYPASS,   pins_from_bsr: 1'b1, pins_hiz: 1'b0};
      OP_FLOAT:  dec = '{sel: DR_BYPASS,   pins_from_bsr: 1'b0, pins_hiz: 1'b1};
      default:   dec = '{sel: DR_BYPASS,   pins_from_bsr: 1'b0, pins_hiz: 1'b0};
    endcase
  end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] ID_VAL   = '0,
  parameter logic [DW-1:0] USER_VAL = '0
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_sel_e    sel,
  output logic       byp_q,
  output logic       word_lsb
);

  logic [DW-1:0] word_q;
  logic          word_sel;

  assign word_sel = (sel == DR_IDENT) || (sel == DR_USER);

  always_ff @(posedge tck) begin
    if (rst) byp_q <= 1'b0;
    else if (sel == DR_BYPASS) begin
      if (state == TS_DR_CAP)      byp_q <= 1'b0;
      else if (state == TS_DR_SHF) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) word_q <= '0;
    else if (word_sel) begin
      if (state == TS_DR_CAP)      word_q <= (sel == DR_IDENT) ? ID_VAL : USER_VAL;
      else if (state == TS_DR_SHF) word_q <= {tdi, word_q[DW-1:1]};
    end
  end

  assign word_lsb = word_q[0];

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h5A3C,
  parameter logic [10:0] ID_MFR     = 11'h2B5,
  parameter logic [31:0] USER_CODE  = 32'hC0DE_1234
) (
  input  logic tck,
  input  logic rst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  input  logic bsr_tdo,
  output logic bsr_sel,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic pins_from_bsr,
  output logic pins_hiz
);

  localparam int          DW     = 32;
  localparam logic [DW-1:0] ID_VAL = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  tap_state_e      st;
  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_act;
  ins_dec_t        dec;
  logic            byp_q;
  logic            word_lsb;
  logic            tdo_nxt;
  logic            in_shift;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (st)
  );

  tap_ir u_ir (
    .tck      (tck),
    .rst      (rst),
    .tdi      (tdi),
    .state    (st),
    .ir_shift (ir_shift),
    .ir_act   (ir_act)
  );

  tap_decode u_dec (
    .ir_act (ir_act),
    .dec    (dec)
  );

  tap_dr #(
    .DW       (DW),
    .ID_VAL   (ID_VAL),
    .USER_VAL (USER_CODE)
  ) u_dr (
    .tck      (tck),
    .rst      (rst),
    .tdi      (tdi),
    .state    (st),
    .sel      (dec.sel),
    .byp_q    (byp_q),
    .word_lsb (word_lsb)
  );

  assign bsr_sel       = (dec.sel == DR_BOUNDARY);
  assign bsr_capture   = bsr_sel && (st == TS_DR_CAP);
  assign bsr_shift     = bsr_sel && (st == TS_DR_SHF);
  assign bsr_update    = bsr_sel && (st == TS_DR_UPD);
  assign pins_from_bsr = dec.pins_from_bsr;
  assign pins_hiz      = dec.pins_hiz;

  assign in_shift = (st == TS_IR_SHF) || (st == TS_DR_SHF);

  always_comb begin
    tdo_nxt = 1'b0;
    if (st == TS_IR_SHF) tdo_nxt = ir_shift[0];
    else if (st == TS_DR_SHF) begin
      case (dec.sel)
        DR_BOUNDARY:       tdo_nxt = bsr_tdo;
        DR_IDENT, DR_USER: tdo_nxt = word_lsb;
        default:           tdo_nxt = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_en <= in_shift;
    end
  end

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_shift,
  input logic [IR_W-1:0] ir_act,
  input logic            tdo_en,
  input logic            bsr_sel,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pins_from_bsr,
  input logic            pins_hiz
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (rst)        ones_cnt <= '0;
    else if (!tms)  ones_cnt <= '0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt >= 3'd5) |-> (state == TS_RESET));

  // R2
  tdo_en_shift_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_en == ((state == TS_IR_SHF) || (state == TS_DR_SHF)));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state == TS_IR_CAP) |=> (ir_shift == 10'b0101010101));

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (rst)
    ((state != TS_IR_UPD) && (state != TS_RESET)) |=> $stable(ir_act));

  // R9
  bsr_strobe_chk: assert property (@(posedge tck) disable iff (rst)
    $onehot0({bsr_capture, bsr_shift, bsr_update}) &&
    (!(bsr_capture || bsr_shift || bsr_update) || bsr_sel));

  // R10
  pin_mode_excl_chk: assert property (@(posedge tck) disable iff (rst)
    !(pins_from_bsr && pins_hiz));

  // R12
  reset_ident_chk: assert property (@(posedge tck)
    rst |=> ((state == TS_RESET) && (ir_act == OP_IDENT)));

endmodule

bind tap_port tap_port_chk u_chk (
  .tck           (tck),
  .rst           (rst),
  .tms           (tms),
  .state         (st),
  .ir_shift      (ir_shift),
  .ir_act        (ir_act),
  .tdo_en        (tdo_en),
  .bsr_sel       (bsr_sel),
  .bsr_capture   (bsr_capture),
  .bsr_shift     (bsr_shift),
  .bsr_update    (bsr_update),
  .pins_from_bsr (pins_from_bsr),
  .pins_hiz      (pins_hiz)
);

// File: tb/tap_port_tb.sv
module tap_port_tb;

  localparam int PERIOD = 10;
  localparam logic [31:0] EXP_ID   = 32'h15A3C56B;
  localparam logic [31:0] EXP_USER = 32'hC0DE1234;
  localparam logic [9:0] C_EXTEST = 10'h000, C_SAMPLE = 10'h005, C_IDENT = 10'h006,
                         C_USER = 10'h007, C_CLAMP = 10'h00A, C_FLOAT = 10'h00B,
                         C_IOCFG = 10'h00D, C_BYP = 10'h3FF;
  // model state numbering (bench-local)
  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4, M_E1DR = 5,
                 M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_SHIR = 11,
                 M_E1IR = 12, M_PIR = 13, M_E2IR = 14, M_UIR = 15;

  logic tck = 1'b0;
  logic rst, tms, tdi, bsr_tdo;
  logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update, pins_from_bsr, pins_hiz;

  int checks = 0;
  int errors = 0;

  int       ms;
  logic [9:0] m_irs, m_ira;
  bit       m_byp;
  bit       m_dq[$];

  always #(PERIOD/2) tck = ~tck;

  tap_port #(
    .ID_VERSION (4'h1),
    .ID_PART    (16'h5A3C),
    .ID_MFR     (11'h2B5),
    .USER_CODE  (32'hC0DE1234)
  ) u_dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bsr_tdo(bsr_tdo), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .pins_from_bsr(pins_from_bsr), .pins_hiz(pins_hiz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_of(input int s, input bit t);
    case (s)
      M_TLR:  return t ? M_TLR : M_RTI;
      M_RTI:  return t ? M_SDR : M_RTI;
      M_SDR:  return t ? M_SIR : M_CDR;
      M_CDR:  return t ? M_E1DR : M_SHDR;
      M_SHDR: return t ? M_E1DR : M_SHDR;
      M_E1DR: return t ? M_UDR : M_PDR;
      M_PDR:  return t ? M_E2DR : M_PDR;
      M_E2DR: return t ? M_UDR : M_SHDR;
      M_UDR:  return t ? M_SDR : M_RTI;
      M_SIR:  return t ? M_TLR : M_CIR;
      M_CIR:  return t ? M_E1IR : M_SHIR;
      M_SHIR: return t ? M_E1IR : M_SHIR;
      M_E1IR: return t ? M_UIR : M_PIR;
      M_PIR:  return t ? M_E2IR : M_PIR;
      M_E2IR: return t ? M_UIR : M_SHIR;
      default: return t ? M_SDR : M_RTI;
    endcase
  endfunction

  // 0 bypass, 1 ident, 2 user, 3 boundary
  function automatic int kind_of(input logic [9:0] op);
    if (op == C_EXTEST || op == C_SAMPLE) return 3;
    if (op == C_IDENT) return 1;
    if (op == C_USER) return 2;
    return 0;
  endfunction

  task automatic model_edge();
    int k;
    logic [31:0] w;
    if (rst) begin
      ms = M_TLR; m_ira = C_IDENT; m_irs = '0; m_byp = 1'b0;
      return;
    end
    k = kind_of(m_ira);
    if (ms == M_TLR) m_ira = C_IDENT;
    if (ms == M_CIR) m_irs = 10'b0101010101;
    if (ms == M_SHIR) m_irs = {tdi, m_irs[9:1]};
    if (ms == M_UIR) m_ira = m_irs;
    if (ms == M_CDR) begin
      if (k == 0) m_byp = 1'b0;
      if (k == 1 || k == 2) begin
        w = (k == 1) ? EXP_ID : EXP_USER;
        m_dq.delete();
        for (int i = 0; i < 32; i++) m_dq.push_back(w[i]);
      end
    end
    if (ms == M_SHDR) begin
      if (k == 0) m_byp = tdi;
      if (k == 1 || k == 2) begin
        void'(m_dq.pop_front());
        m_dq.push_back(tdi);
      end
    end
    ms = next_of(ms, tms);
  endtask

  task automatic compare_all();
    int k;
    bit en, exp_tdo, bs;
    k = kind_of(m_ira);
    en = (ms == M_SHIR) || (ms == M_SHDR);
    chk(tdo_en == en, "R2 tdo_en", tdo_en, en);
    if (en) begin
      if (ms == M_SHIR) exp_tdo = m_irs[0];
      else if (k == 3) exp_tdo = bsr_tdo;
      else if (k == 0) exp_tdo = m_byp;
      else exp_tdo = m_dq[0];
      chk(tdo == exp_tdo, "R11 tdo", tdo, exp_tdo);
    end
    bs = (k == 3);
    chk(bsr_sel == bs && bsr_capture == (bs && ms == M_CDR) &&
        bsr_shift == (bs && ms == M_SHDR) && bsr_update == (bs && ms == M_UDR),
        "R9 strobes", {bsr_sel, bsr_capture, bsr_shift, bsr_update},
        {bs, bs && ms == M_CDR, bs && ms == M_SHDR, bs && ms == M_UDR});
    chk(pins_from_bsr == (m_ira == C_EXTEST || m_ira == C_CLAMP) && pins_hiz == (m_ira == C_FLOAT),
        "R10 pin modes", {pins_from_bsr, pins_hiz},
        {m_ira == C_EXTEST || m_ira == C_CLAMP, m_ira == C_FLOAT});
  endtask

  task automatic tick(input bit t, input bit d);
    tms = t; tdi = d; bsr_tdo = 1'($urandom);
    @(posedge tck);
    model_edge();
    @(negedge tck);
    #1;
    compare_all();
  endtask

  task automatic goto_shdr();
    tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  task automatic goto_shir();
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  // starts in a shift state, ends in Exit1
  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
  endtask

  task automatic finish_upd();
    tick(1, 0); tick(0, 0);
  endtask

  task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
    logic [63:0] o;
    goto_shir();
    shift_bits(10, {54'd0, op}, o);
    cap = o[9:0];
    finish_upd();
  endtask

  task automatic read_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    goto_shdr();
    shift_bits(n, din, dout);
    finish_upd();
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] o;
    logic [9:0]  c;
    rst = 1'b1; tms = 1'b1; tdi = 1'b0; bsr_tdo = 1'b0;
    ms = M_TLR; m_ira = C_IDENT; m_irs = '0; m_byp = 1'b0;
    tick(1, 0); tick(1, 0);
    rst = 1'b0;
    tick(1, 0);
    // R12 reset state
    chk(tdo_en == 0 && bsr_sel == 0 && pins_from_bsr == 0 && pins_hiz == 0, "R12 reset outputs",
        {tdo_en, bsr_sel, pins_from_bsr, pins_hiz}, 0);
    tick(0, 0);

    // R5 identification word after reset
    read_dr(32, 64'h0, o);
    chk(o[31:0] == EXP_ID, "R5 ident word", o[31:0], EXP_ID);

    // R3 capture pattern
    load_ir(C_SAMPLE, c);
    chk(c == 10'b0101010101, "R3 IR capture", c, 10'b0101010101);
    chk(bsr_sel == 1, "R9 sample selects boundary", bsr_sel, 1);
    tick(1, 0); tick(0, 0);
    chk(bsr_capture == 1, "R9 capture strobe", bsr_capture, 1);
    tick(0, 0);
    chk(bsr_shift == 1 && tdo == bsr_tdo, "R9 shift path", {bsr_shift, tdo}, {1'b1, bsr_tdo});
    shift_bits(12, 64'hA5C, o);
    tick(1, 0);
    chk(bsr_update == 1, "R9 update strobe", bsr_update, 1);
    tick(0, 0);

    // R7 bypass
    load_ir(C_BYP, c);
    read_dr(8, 64'hB3, o);
    chk(o[7:0] == 8'h66, "R7 bypass delay", o[7:0], 8'h66);

    // R8 unlisted opcode
    load_ir(10'h155, c);
    read_dr(8, 64'h5C, o);
    chk(o[7:0] == 8'hB8, "R8 unlisted as bypass", o[7:0], 8'hB8);

    // R10 float
    load_ir(C_FLOAT, c);
    chk(pins_hiz == 1 && pins_from_bsr == 0, "R10 float mode", {pins_hiz, pins_from_bsr}, 2'b10);
    read_dr(8, 64'h0F, o);
    chk(o[7:0] == 8'h1E, "R8 float as bypass", o[7:0], 8'h1E);

    // R4 instruction stays active while a new one shifts in
    goto_shir();
    shift_bits(10, {54'd0, C_EXTEST}, o);
    chk(pins_hiz == 1 && pins_from_bsr == 0, "R4 hold in Exit1-IR", {pins_hiz, pins_from_bsr}, 2'b10);
    tick(1, 0);
    chk(pins_hiz == 1 && pins_from_bsr == 0, "R4 hold in Update-IR", {pins_hiz, pins_from_bsr}, 2'b10);
    tick(0, 0);
    chk(pins_hiz == 0 && pins_from_bsr == 1 && bsr_sel == 1, "R4 R10 external test active",
        {pins_hiz, pins_from_bsr, bsr_sel}, 3'b011);

    // R10 clamp
    load_ir(C_CLAMP, c);
    chk(pins_from_bsr == 1 && bsr_sel == 0, "R10 clamp mode", {pins_from_bsr, bsr_sel}, 2'b10);
    read_dr(4, 64'h9, o);
    chk(o[3:0] == 4'h2, "R8 clamp as bypass", o[3:0], 4'h2);

    // R8 io-config
    load_ir(C_IOCFG, c);
    read_dr(4, 64'h6, o);
    chk(o[3:0] == 4'hC, "R8 io-config as bypass", o[3:0], 4'hC);

    // R6 user word
    load_ir(C_USER, c);
    read_dr(32, 64'h0, o);
    chk(o[31:0] == EXP_USER, "R6 user word", o[31:0], EXP_USER);

    // R11 edge timing entering Shift-DR
    tick(1, 0); tick(0, 0);
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck);
    model_edge();
    #1;
    chk(tdo_en == 0, "R11 tdo_en held after rising edge", tdo_en, 0);
    @(negedge tck);
    #1;
    compare_all();
    chk(tdo_en == 1 && tdo == EXP_USER[0], "R11 tdo at falling edge", {tdo_en, tdo}, {1'b1, EXP_USER[0]});
    shift_bits(32, 64'h0, o);
    chk(o[31:0] == EXP_USER, "R6 user word rescan", o[31:0], EXP_USER);
    finish_upd();

    // R1 five ones from mid Shift-DR
    goto_shdr();
    tick(0, 1); tick(0, 0); tick(0, 1);
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk(tdo_en == 0, "R1 left shift state", tdo_en, 0);
    tick(0, 0);
    read_dr(32, 64'h0, o);
    chk(o[31:0] == EXP_ID, "R1 ident after five ones", o[31:0], EXP_ID);

    // R12 synchronous reset in Shift-DR
    load_ir(C_USER, c);
    goto_shdr();
    rst = 1'b1;
    tick(0, 0);
    rst = 1'b0;
    chk(tdo_en == 0, "R12 reset clears tdo_en", tdo_en, 0);
    tick(0, 0);
    read_dr(32, 64'h0, o);
    chk(o[31:0] == EXP_ID, "R12 ident after reset", o[31:0], EXP_ID);

    // R2 pause states are not shift states
    goto_shir();
    tick(1, 0); tick(0, 0);
    chk(tdo_en == 0, "R2 Pause-IR", tdo_en, 0);
    tick(1, 0); tick(0, 0);
    chk(tdo_en == 1, "R2 back to Shift-IR", tdo_en, 1);
    tick(1, 1);
    finish_upd();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule